// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a down-counting watchdog for system supervision. Software programs a 6-bit timeout expressed in periods of a 32 Hz tick (31.25 ms each, so 1 gives 31.25 ms and 63 gives just under 2 s). Software must then keep restarting the count before it runs out. If the count expires without being restarted, a sticky watchdog flag is raised. The flag can also drive an interrupt request when that source is enabled.

The control register carries the timeout field, a guard bit and a restart strobe. The guard bit protects the timeout field from stray writes: the field accepts a new value only if the guard was left at 0 by an earlier write. The restart strobe reloads the count without touching the timeout. A read strobe on the flags register clears the flag.

The 32 Hz source and the interrupt pin driver are outside the block. The block sees a one-cycle tick enable and drives a level request.

Top module: `wdog_timer`

## Requirements
- R1: After reset the flag and interrupt request are 0, the timeout is 0 and the guard bit is 1, so the control readback is 0x40.
- R2: A write to the control register (address 0) takes bits [5:0] as the new timeout only if the guard bit (bit 6) held 0 before that write. Otherwise the timeout stays unchanged. Every control write stores bit 6 as the new guard value.
- R3: The control readback is {1'b0, guard, timeout[5:0]}. The restart strobe (bit 7) always reads 0.
- R4: A timeout of 0 disables the watchdog: ticks never set the flag.
- R5: With a timeout T of 1 to 63, the flag sets on the T-th tick after the latest reload. A reload happens on every accepted timeout write.
- R6: A control write with bit 7 set reloads the count from the current timeout. A control write with bit 7 clear leaves the count running.
- R7: After an expiry the count reloads from the timeout and keeps running. The flag stays set until it is cleared.
- R8: A flags read strobe clears the flag. An expiry in the same cycle wins, and the flag stays 1.
- R9: The interrupt request equals the flag ANDed with the enable. The enable is bit 0 of a write to address 1.
- R10: If a reload and a tick fall in the same cycle, the reload wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 32 Hz count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: control register, 1: interrupt enable register |
| wr_data_i | input | 8 | Write data |
| flags_rd_i | input | 1 | Flags register read strobe (clears the flag) |
| cfg_rdata_o | output | 8 | Control register readback |
| wdog_flag_o | output | 1 | Sticky watchdog expiry flag |
| wdog_irq_o | output | 1 | Watchdog interrupt request |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is the tick that brings the count to zero and the flags read strobe. The second pair is a restart write and a tick. The bench brings the count to one remaining period and then drives both stimuli of a pair in one cycle. In the first case the flag must still read 1 afterwards. In the second case the flag must stay 0 for a further T-1 ticks and rise exactly on the T-th.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned TMO_W  = 6;
  localparam int unsigned DATA_W = 8;

  // Value of the count after one tick (no reload pending)
  function automatic logic [TMO_W-1:0] wd_step(input logic [TMO_W-1:0] cnt,
                                               input logic [TMO_W-1:0] tmo);
    if (cnt <= 1) return tmo;
    return cnt - 1'b1;
  endfunction

  // True when a tick at this count ends the period
  function automatic logic wd_hits_zero(input logic [TMO_W-1:0] cnt,
                                        input logic [TMO_W-1:0] tmo);
    return (tmo != '0) && (cnt <= 1);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int unsigned TMO_W  = wdog_pkg::TMO_W,
  parameter int unsigned DATA_W = wdog_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [TMO_W-1:0]  tmo_o,
  output logic              guard_o,
  output logic              ien_o,
  output logic              reload_o,
  output logic [TMO_W-1:0]  load_val_o
);
  localparam int unsigned GUARD_BIT = TMO_W;
  localparam int unsigned KICK_BIT  = DATA_W - 1;

  logic [TMO_W-1:0] tmo_q;
  logic             guard_q;
  logic             ien_q;
  logic             ctrl_wr;
  logic             tmo_accept;

  assign ctrl_wr    = wr_en_i && !wr_addr_i;
  assign tmo_accept = ctrl_wr && !guard_q;
  assign reload_o   = tmo_accept || (ctrl_wr && wr_data_i[KICK_BIT]);
  assign load_val_o = tmo_accept ? wr_data_i[TMO_W-1:0] : tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q   <= '0;
      guard_q <= 1'b1;
      ien_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i) begin
        ien_q <= wr_data_i[0];
      end else begin
        guard_q <= wr_data_i[GUARD_BIT];
        if (tmo_accept) tmo_q <= wr_data_i[TMO_W-1:0];
      end
    end
  end

  assign tmo_o   = tmo_q;
  assign guard_o = guard_q;
  assign ien_o   = ien_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned TMO_W = wdog_pkg::TMO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [TMO_W-1:0] load_val_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic [TMO_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;

  assign expire_o = !reload_i && tick_i && wdog_pkg::wd_hits_zero(cnt_q, tmo_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (reload_i)            cnt_q <= load_val_i;
    else if (tick_i && tmo_i != '0) cnt_q <= wdog_pkg::wd_step(cnt_q, tmo_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_flag.sv
module wdog_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clear_i,
  output logic flag_o
);
  logic flag_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clear_i)  flag_q <= 1'b0;
  end
  assign flag_o = flag_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned TMO_W  = wdog_pkg::TMO_W,
  parameter int unsigned DATA_W = wdog_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flags_rd_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              wdog_flag_o,
  output logic              wdog_irq_o
);
  localparam int unsigned PAD_W = DATA_W - TMO_W - 1;

  logic [TMO_W-1:0] tmo;
  logic [TMO_W-1:0] load_val;
  logic [TMO_W-1:0] cnt;
  logic             guard;
  logic             ien;
  logic             reload;
  logic             expire;
  logic             flag;

  wdog_regs #(.TMO_W(TMO_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tmo_o(tmo), .guard_o(guard), .ien_o(ien),
    .reload_o(reload), .load_val_o(load_val)
  );

  wdog_counter #(.TMO_W(TMO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(reload),
    .load_val_i(load_val), .tmo_i(tmo), .cnt_o(cnt), .expire_o(expire)
  );

  wdog_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .clear_i(flags_rd_i),
    .flag_o(flag)
  );

  assign cfg_rdata_o = {{PAD_W{1'b0}}, guard, tmo};
  assign wdog_flag_o = flag;
  assign wdog_irq_o  = flag && ien;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned TMO_W  = wdog_pkg::TMO_W,
  parameter int unsigned DATA_W = wdog_pkg::DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic              wr_addr_i,
  input logic              flags_rd_i,
  input logic              wdog_flag_o,
  input logic              wdog_irq_o,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic              expire,
  input logic [TMO_W-1:0]  tmo,
  input logic              guard
);
  // R2: a guarded control write leaves the timeout unchanged
  a_r2_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_addr_i && guard) |=> $stable(cfg_rdata_o[TMO_W-1:0]));

  // R4: a zero timeout never expires
  a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo == '0) |-> !expire);

  // R5: the flag only rises after an expiry
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_flag_o) |-> $past(expire));

  // R7: the flag is sticky without a read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_flag_o && !flags_rd_i) |=> wdog_flag_o);

  // R8: a read without an expiry clears the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd_i && !expire) |=> !wdog_flag_o);

  // R9: no request without the flag
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_irq_o |-> wdog_flag_o);
endmodule

bind wdog_timer wdog_timer_chk #(.TMO_W(TMO_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .flags_rd_i(flags_rd_i), .wdog_flag_o(wdog_flag_o), .wdog_irq_o(wdog_irq_o),
  .cfg_rdata_o(cfg_rdata_o), .expire(expire), .tmo(tmo), .guard(guard)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       wr_addr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       flags_rd_i = 1'b0;
  logic [7:0] cfg_rdata_o;
  logic       wdog_flag_o;
  logic       wdog_irq_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .flags_rd_i(flags_rd_i),
    .cfg_rdata_o(cfg_rdata_o), .wdog_flag_o(wdog_flag_o), .wdog_irq_o(wdog_irq_o)
  );

  // Timeout table: each entry is walked through a full period
  localparam logic [5:0] TMO_TAB [5] = '{6'd1, 6'd2, 6'd7, 6'd33, 6'd63};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, driven at a falling edge; returns at the next one
  task automatic step(input logic we, input logic addr, input logic [7:0] d,
                      input logic tk, input logic rd);
    wr_en_i = we; wr_addr_i = addr; wr_data_i = d; tick_i = tk; flags_rd_i = rd;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0; flags_rd_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    step(1'b1, 1'b0, d, 1'b0, 1'b0);
  endtask

  task automatic clr_flag();
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 flag", {7'd0, wdog_flag_o}, 8'h00);
    check("R1 irq", {7'd0, wdog_irq_o}, 8'h00);
    check("R1 readback", cfg_rdata_o, 8'h40);

    // R4: zero timeout never expires
    ticks(70);
    check("R4 disabled", {7'd0, wdog_flag_o}, 8'h00);

    // R2: guard set at reset blocks the field, but the guard bit itself is stored
    wr_ctrl(8'h05);
    check("R2 blocked", cfg_rdata_o, 8'h00);
    wr_ctrl(8'h05);
    check("R2 accepted", cfg_rdata_o, 8'h05);
    clr_flag();

    // R5: table of timeouts, flag on the T-th tick
    for (int k = 0; k < 5; k++) begin
      wr_ctrl({2'b00, TMO_TAB[k]});
      ticks(int'(TMO_TAB[k]) - 1);
      check("R5 before expiry", {7'd0, wdog_flag_o}, 8'h00);
      ticks(1);
      check("R5 at expiry", {7'd0, wdog_flag_o}, 8'h01);
      clr_flag();
      check("R8 read clears", {7'd0, wdog_flag_o}, 8'h00);
    end

    // R6 / R3: lock timeout 4, then restart with the guard kept
    wr_ctrl(8'h44);
    check("R3 locked readback", cfg_rdata_o, 8'h44);
    ticks(3);
    wr_ctrl(8'hC0);
    check("R3 strobe reads 0 / R2 field kept", cfg_rdata_o, 8'h44);
    ticks(3);
    check("R6 restart delays expiry", {7'd0, wdog_flag_o}, 8'h00);
    ticks(1);
    check("R6 expiry after restart", {7'd0, wdog_flag_o}, 8'h01);
    clr_flag();
    ticks(2);
    wr_ctrl(8'h40);
    ticks(2);
    check("R6 strobe 0 no restart", {7'd0, wdog_flag_o}, 8'h01);

    // R7: keeps running after expiry
    ticks(4);
    check("R7 sticky", {7'd0, wdog_flag_o}, 8'h01);
    clr_flag();
    ticks(3);
    check("R7 reloaded period", {7'd0, wdog_flag_o}, 8'h00);
    ticks(1);
    check("R7 second expiry", {7'd0, wdog_flag_o}, 8'h01);

    // R9: interrupt gating
    check("R9 irq disabled", {7'd0, wdog_irq_o}, 8'h00);
    step(1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
    check("R9 irq enabled", {7'd0, wdog_irq_o}, 8'h01);
    clr_flag();
    check("R9 irq follows flag", {7'd0, wdog_irq_o}, 8'h00);

    // R8: expiry and read in the same cycle
    ticks(3);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
    check("R8 expiry beats read", {7'd0, wdog_flag_o}, 8'h01);
    clr_flag();

    // R10: restart in the same cycle as the expiring tick
    ticks(3);
    step(1'b1, 1'b0, 8'hC0, 1'b1, 1'b0);
    check("R10 no expiry", {7'd0, wdog_flag_o}, 8'h00);
    ticks(3);
    check("R10 full period", {7'd0, wdog_flag_o}, 8'h00);
    ticks(1);
    check("R10 expiry", {7'd0, wdog_flag_o}, 8'h01);
    check("R9 irq with flag", {7'd0, wdog_irq_o}, 8'h01);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule